// File: doc/BRIEF.md
# Overlay Window Fetch Address Generator

This block produces the memory read requests for a single overlay window. The window is a rectangle taken out of a wider framebuffer. Software programs a start address that points at the window's top-left pixel, an end address, the number of bytes to fetch per window line, and the number of bytes to skip between the end of one window line and the start of the next. At every frame-start strobe the generator reloads the start address. It then walks the window line by line and issues word-aligned bursts until it reaches the end address.

The start address is the framebuffer base plus x times bytes per pixel plus y times the row pitch. The per-line byte count is the window width times bytes per pixel. The skip is the framebuffer width minus the window width, times bytes per pixel. The end address is the start address plus framebuffer width times window height times bytes per pixel. The maximum burst size follows from the pixel depth, and the last burst of each line is shortened so that it never reaches into the skipped bytes. Requests leave on a valid/ready port that carries a byte address and a length in 32-bit words.

Top module: `win_fetch_agen`

## Requirements
- R1: While reset is held and after it is released, `req_valid_o` stays low until a frame start arrives with both enables set.
- R2: A request is issued only when both `cfg_win_en_i` and `cfg_chan_en_i` are high. A frame start with either enable low produces no requests.
- R3: The first request after a frame start carries `cfg_start_addr_i` as its address.
- R4: Within a line, bursts follow each other with no gap. Each burst's address is the previous address plus 4 times the previous length. The lengths of one line add up to `cfg_page_bytes_i`/4 words.
- R5: The first burst of each line after the first starts `cfg_skip_bytes_i` bytes beyond the last byte fetched on the line before.
- R6: The maximum burst length depends on `cfg_depth_i` (bits per pixel): 4 words at 1, 8 words at 2, 4 or 8, and 16 words at 16, 24 or 32.
- R7: Any other `cfg_depth_i` value uses the 16-word maximum.
- R8: When the remaining words of a line are fewer than the maximum, the last burst of the line carries exactly the remaining count.
- R9: When the address after a burst reaches or passes `cfg_end_addr_i`, no further request is issued until the next frame start.
- R10: A frame start in the middle of a frame restarts the walk at `cfg_start_addr_i`. A request that is already pending is still delivered unchanged.
- R11: While `req_valid_o` is high and `req_ready_i` is low, `req_valid_o`, `req_addr_o` and `req_len_o` do not change.
- R12: Every request has a length between 1 and the largest burst size. Start address, page width and skip must be word multiples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_start_addr_i | input | AW | Byte address of the window's top-left pixel |
| cfg_end_addr_i | input | AW | Byte address at which fetching stops |
| cfg_page_bytes_i | input | PW | Bytes fetched per window line |
| cfg_skip_bytes_i | input | PW | Bytes skipped after each window line |
| cfg_depth_i | input | 6 | Bits per pixel |
| cfg_win_en_i | input | 1 | Window enable |
| cfg_chan_en_i | input | 1 | Fetch channel enable |
| frame_start_i | input | 1 | One-cycle frame-start strobe |
| req_valid_o | output | 1 | Burst request valid |
| req_ready_i | input | 1 | Burst request accepted |
| req_addr_o | output | AW | Burst byte address |
| req_len_o | output | LEN_W | Burst length in words |

## Verification
The assertions check three things on every cycle: a stalled request stays frozen, every request length lies within the legal range, and a new request appears only after both enables were high. Only the bench's scenarios can show the address sequence itself. That sequence covers line stepping, skipping the stride gap, shortening the last burst of a line, the choice of maximum burst by depth, the stop at the end address and the restart on a mid-frame strobe. The bench predicts every burst from the configuration and compares each accepted request against that prediction while the ready line stalls at irregular times.

// File: rtl/wfetch_pkg.sv
package wfetch_pkg;

  typedef enum logic [1:0] {
    CAP_SMALL = 2'd0,
    CAP_MID   = 2'd1,
    CAP_LARGE = 2'd2
  } cap_e;

  // depth in bits per pixel -> burst class; unknown depths use the large class
  function automatic cap_e depth_class(input logic [5:0] bpp);
    case (bpp)
      6'd1:                 depth_class = CAP_SMALL;
      6'd2, 6'd4, 6'd8:     depth_class = CAP_MID;
      default:              depth_class = CAP_LARGE;
    endcase
  endfunction

endpackage

// File: rtl/wfetch_burst_sel.sv
module wfetch_burst_sel
  import wfetch_pkg::*;
#(
  parameter int unsigned BURST_S = 4,
  parameter int unsigned BURST_M = 8,
  parameter int unsigned BURST_L = 16,
  localparam int unsigned LEN_W  = $clog2(BURST_L + 1)
) (
  input  logic [5:0]       depth_i,
  output logic [LEN_W-1:0] cap_o
);

  cap_e cls;

  always_comb begin
    cls = depth_class(depth_i);
    unique case (cls)
      CAP_SMALL: cap_o = LEN_W'(BURST_S);
      CAP_MID:   cap_o = LEN_W'(BURST_M);
      default:   cap_o = LEN_W'(BURST_L);
    endcase
  end

endmodule

// File: rtl/wfetch_walker.sv
module wfetch_walker #(
  parameter int unsigned AW    = 32,
  parameter int unsigned PW    = 16,
  parameter int unsigned LEN_W = 5,
  localparam int unsigned WLW  = PW - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             load_ok_i,
  input  logic             issue_i,
  input  logic [AW-1:0]    start_addr_i,
  input  logic [AW-1:0]    end_addr_i,
  input  logic [PW-1:0]    page_bytes_i,
  input  logic [PW-1:0]    skip_bytes_i,
  input  logic [LEN_W-1:0] cap_i,
  output logic             active_o,
  output logic [AW-1:0]    addr_o,
  output logic [LEN_W-1:0] len_o
);

  logic [AW-1:0]  addr_q, nxt_addr;
  logic [WLW-1:0] left_q, page_words, cap_ext, len_w;
  logic           active_q, line_done;

  always_comb begin
    page_words = WLW'(page_bytes_i >> 2);
    cap_ext    = WLW'(cap_i);
    len_w      = (left_q < cap_ext) ? left_q : cap_ext;
    line_done  = (left_q == len_w);
    nxt_addr   = addr_q + (AW'(len_w) << 2);
    if (line_done) nxt_addr = nxt_addr + AW'(skip_bytes_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      addr_q   <= start_addr_i;
      left_q   <= page_words;
      active_q <= load_ok_i && (page_words != '0) && (start_addr_i < end_addr_i);
    end else if (issue_i) begin
      addr_q <= nxt_addr;
      left_q <= line_done ? page_words : left_q - len_w;
      if (nxt_addr >= end_addr_i) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign addr_o   = addr_q;
  assign len_o    = LEN_W'(len_w);

endmodule

// File: rtl/wfetch_req_hold.sv
module wfetch_req_hold #(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ready_i,
  output logic             can_load_o,
  output logic             valid_o,
  output logic [AW-1:0]    addr_o,
  output logic [LEN_W-1:0] len_o
);

  logic             valid_q;
  logic [AW-1:0]    addr_q;
  logic [LEN_W-1:0] len_q;

  assign can_load_o = !valid_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
    end else if (can_load_o) begin
      valid_q <= issue_i;
      if (issue_i) begin
        addr_q <= addr_i;
        len_q  <= len_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign len_o   = len_q;

endmodule

// File: rtl/win_fetch_agen.sv
module win_fetch_agen #(
  parameter int unsigned AW      = 32,
  parameter int unsigned PW      = 16,
  parameter int unsigned BURST_S = 4,
  parameter int unsigned BURST_M = 8,
  parameter int unsigned BURST_L = 16,
  localparam int unsigned LEN_W  = $clog2(BURST_L + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    cfg_start_addr_i,
  input  logic [AW-1:0]    cfg_end_addr_i,
  input  logic [PW-1:0]    cfg_page_bytes_i,
  input  logic [PW-1:0]    cfg_skip_bytes_i,
  input  logic [5:0]       cfg_depth_i,
  input  logic             cfg_win_en_i,
  input  logic             cfg_chan_en_i,
  input  logic             frame_start_i,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic [AW-1:0]    req_addr_o,
  output logic [LEN_W-1:0] req_len_o
);

  logic             fetch_en, can_load, walk_active, issue;
  logic [LEN_W-1:0] cap, walk_len;
  logic [AW-1:0]    walk_addr;

  assign fetch_en = cfg_win_en_i && cfg_chan_en_i;
  assign issue    = can_load && walk_active && fetch_en && !frame_start_i;

  wfetch_burst_sel #(
    .BURST_S(BURST_S), .BURST_M(BURST_M), .BURST_L(BURST_L)
  ) u_burst_sel (
    .depth_i (cfg_depth_i),
    .cap_o   (cap)
  );

  wfetch_walker #(
    .AW(AW), .PW(PW), .LEN_W(LEN_W)
  ) u_walker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (frame_start_i),
    .load_ok_i    (fetch_en),
    .issue_i      (issue),
    .start_addr_i (cfg_start_addr_i),
    .end_addr_i   (cfg_end_addr_i),
    .page_bytes_i (cfg_page_bytes_i),
    .skip_bytes_i (cfg_skip_bytes_i),
    .cap_i        (cap),
    .active_o     (walk_active),
    .addr_o       (walk_addr),
    .len_o        (walk_len)
  );

  wfetch_req_hold #(
    .AW(AW), .LEN_W(LEN_W)
  ) u_req_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue),
    .addr_i     (walk_addr),
    .len_i      (walk_len),
    .ready_i    (req_ready_i),
    .can_load_o (can_load),
    .valid_o    (req_valid_o),
    .addr_o     (req_addr_o),
    .len_o      (req_len_o)
  );

endmodule

// File: rtl/wfetch_checker.sv
module wfetch_checker #(
  parameter int unsigned AW      = 32,
  parameter int unsigned BURST_L = 16,
  localparam int unsigned LEN_W  = $clog2(BURST_L + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_win_en_i,
  input logic             cfg_chan_en_i,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [AW-1:0]    req_addr_o,
  input logic [LEN_W-1:0] req_len_o
);

  assert_hold_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o);

  assert_hold_addr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> $stable(req_addr_o));

  assert_hold_len_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> $stable(req_len_o));

  assert_len_range_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0) && (req_len_o <= LEN_W'(BURST_L)));

  assert_enable_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(cfg_win_en_i && cfg_chan_en_i));

endmodule

bind win_fetch_agen wfetch_checker #(.AW(AW), .BURST_L(BURST_L)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_win_en_i  (cfg_win_en_i),
  .cfg_chan_en_i (cfg_chan_en_i),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .req_addr_o    (req_addr_o),
  .req_len_o     (req_len_o)
);

// File: tb/win_fetch_agen_tb.sv
module win_fetch_agen_tb;
  localparam int AW = 32;
  localparam int PW = 16;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] start_addr = '0, end_addr = '0;
  logic [PW-1:0] page_bytes = '0, skip_bytes = '0;
  logic [5:0]    depth = 6'd16;
  logic          win_en = 1'b0, chan_en = 1'b0, fs = 1'b0;
  logic          ready = 1'b0;
  logic          valid;
  logic [AW-1:0] addr;
  logic [LW-1:0] len;

  int errors = 0;
  int checks = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'h5a;

  logic [AW-1:0] q_addr[$];
  int            q_len[$];
  string         q_tag[$];

  always #4 clk = ~clk;

  win_fetch_agen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_start_addr_i(start_addr), .cfg_end_addr_i(end_addr),
    .cfg_page_bytes_i(page_bytes), .cfg_skip_bytes_i(skip_bytes),
    .cfg_depth_i(depth), .cfg_win_en_i(win_en), .cfg_chan_en_i(chan_en),
    .frame_start_i(fs), .req_valid_o(valid), .req_ready_i(ready),
    .req_addr_o(addr), .req_len_o(len)
  );

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ready_mode)
      0: ready <= 1'b1;
      1: ready <= lfsr[0] | lfsr[2];
      default: ready <= 1'b0;
    endcase
  end

  // monitor / scoreboard
  logic          stall_prev = 1'b0;
  logic [AW-1:0] stall_addr;
  logic [LW-1:0] stall_len;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        checks++;
        if (!valid || addr != stall_addr || len != stall_len) begin
          errors++;
          $display("FAIL R11 stalled request changed: actual v=%0b a=%h l=%0d expected v=1 a=%h l=%0d",
                   valid, addr, len, stall_addr, stall_len);
        end
      end
      stall_prev = valid && !ready;
      stall_addr = addr;
      stall_len  = len;
      if (valid && ready) begin
        checks++;
        if (q_addr.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected request: actual a=%h l=%0d expected none", addr, len);
        end else begin
          automatic logic [AW-1:0] ea = q_addr.pop_front();
          automatic int el = q_len.pop_front();
          automatic string tg = q_tag.pop_front();
          if (addr != ea || int'(len) != el) begin
            errors++;
            $display("FAIL %s request: actual a=%h l=%0d expected a=%h l=%0d", tg, addr, len, ea, el);
          end
        end
      end
    end
  end

  function automatic int max_burst(input logic [5:0] d);
    if (d == 6'd1) return 4;                        // R6
    if (d == 6'd2 || d == 6'd4 || d == 6'd8) return 8; // R6
    return 16;                                      // R6 / R7
  endfunction

  task automatic push_frame(input logic [AW-1:0] s, input int pg, input int sk,
                            input int h, input logic [5:0] d, input string tag, input bit first_only);
    for (int ln = 0; ln < h; ln++) begin
      automatic logic [AW-1:0] a = s + AW'(ln * (pg + sk));
      automatic int left = pg / 4;
      while (left > 0) begin
        automatic int l = (left < max_burst(d)) ? left : max_burst(d);
        q_addr.push_back(a);
        q_len.push_back(l);
        q_tag.push_back((ln == 0 && left == pg / 4) ? "R3" : tag);
        if (first_only) return;
        a += AW'(4 * l);
        left -= l;
      end
    end
  endtask

  task automatic set_cfg(input logic [AW-1:0] s, input int pg, input int sk,
                         input int h, input logic [5:0] d);
    @(negedge clk);
    start_addr = s;
    page_bytes = PW'(pg);
    skip_bytes = PW'(sk);
    end_addr   = s + AW'((pg + sk) * h);
    depth      = d;
  endtask

  task automatic pulse_fs();
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
  endtask

  task automatic drain_and_idle(input string tag);
    int n = 0;
    while (q_addr.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    checks++;
    if (q_addr.size() != 0) begin
      errors++;
      $display("FAIL %s missing requests: actual pending=%0d expected 0", tag, q_addr.size());
      q_addr.delete(); q_len.delete(); q_tag.delete();
    end
    repeat (30) @(negedge clk);  // monitor flags anything extra (R9)
  endtask

  task automatic run_frame(input logic [AW-1:0] s, input int pg, input int sk,
                           input int h, input logic [5:0] d, input string tag);
    set_cfg(s, pg, sk, h, d);
    push_frame(s, pg, sk, h, d, tag, 1'b0);
    pulse_fs();
    drain_and_idle(tag);
  endtask

  task automatic expect_silent(input string tag);
    int seen = 0;
    pulse_fs();
    repeat (40) begin @(negedge clk); if (valid) seen++; end
    checks++;
    if (seen != 0) begin
      errors++;
      $display("FAIL %s request while disabled: actual cycles=%0d expected 0", tag, seen);
    end
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    checks++;
    if (valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid in reset: actual %b expected 0", valid);
    end
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    checks++;
    if (valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid before frame start: actual %b expected 0", valid);
    end

    win_en = 1'b1; chan_en = 1'b1;
    ready_mode = 0;
    // R8: 20 words per line at 16 bpp -> 16 + 4; R5 skip of 48 bytes
    run_frame(32'h0000_1000, 80, 48, 3, 6'd16, "R8");
    ready_mode = 1;
    run_frame(32'h0000_2000, 80, 48, 3, 6'd16, "R5");
    run_frame(32'h0000_3000, 24, 8, 2, 6'd1, "R6");     // 4 + 2
    run_frame(32'h0000_4000, 32, 0, 2, 6'd8, "R6");     // exact 8
    run_frame(32'h0000_5000, 40, 24, 2, 6'd2, "R6");    // 8 + 2
    run_frame(32'h0000_6000, 72, 8, 2, 6'd4, "R4");     // 8,8,2
    run_frame(32'h0000_7000, 128, 16, 2, 6'd24, "R4");  // 16,16
    run_frame(32'h0000_8000, 68, 4, 2, 6'd32, "R8");    // 16 + 1
    run_frame(32'h0000_9000, 100, 12, 2, 6'd5, "R7");   // unsupported depth -> 16,9
    run_frame(32'h0000_A000, 16, 0, 1, 6'd12, "R7");    // single line

    // R2: either enable low
    set_cfg(32'h0000_B000, 32, 0, 2, 6'd16);
    win_en = 1'b0;
    expect_silent("R2");
    win_en = 1'b1; chan_en = 1'b0;
    expect_silent("R2");
    chan_en = 1'b1;

    // R10: restart while a request is stalled
    ready_mode = 2;
    set_cfg(32'h0001_0000, 64, 64, 4, 6'd16);
    push_frame(32'h0001_0000, 64, 64, 4, 6'd16, "R10", 1'b1);
    pulse_fs();
    repeat (4) @(negedge clk);
    set_cfg(32'h0002_0000, 40, 8, 2, 6'd8);
    push_frame(32'h0002_0000, 40, 8, 2, 6'd8, "R10", 1'b0);
    pulse_fs();
    repeat (3) @(negedge clk);
    ready_mode = 1;
    drain_and_idle("R10");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog expired: actual hung expected done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule